// File: doc/BRIEF.md
# Multi-Cycle Accumulator Processor with State-Machine Controller

This block is a small processor that holds one accumulator and runs programs of three instruction kinds: load, store and add. Each instruction is an 8-bit word with a 2-bit operation code in the upper two bits and a 6-bit data address in the lower six. A program counter picks words from an instruction memory. A data memory supplies operands and takes stored results. A controller state machine walks each instruction through a fetch step, an operand-read step and one or two execute steps. Load and store finish in three cycles and add finishes in four. The controller's outputs depend only on its state.

Both memories are filled through a test write port, normally while reset is held. A read-only peek port exposes any data-memory word. The controller state, the three datapath control signals, a completion pulse and an error flag are all brought out, so a bench can follow execution cycle by cycle. The unused operation code sends the controller into a trap state. The controller stays there until the next reset.

Top module: `acc_cpu`

## Requirements
- R1: Synchronous active-high reset puts the controller in the fetch state (code 000) and clears the program counter and the accumulator to 0. While reset holds, no write enable and no completion pulse is asserted.
- R2: Operation code 00 (load) copies data memory at the instruction's address into the accumulator. The accumulator shows the new value in the cycle after the instruction's completion pulse.
- R3: Operation code 01 (store) writes the accumulator into data memory at the instruction's address. The accumulator does not change.
- R4: Operation code 10 (add) replaces the accumulator with the accumulator plus data memory at the address, wrapped modulo 256 with no carry kept.
- R5: The state codes are fetch 000, operand read 001, add execute 100, accumulator load 011, accumulator write-back 010, memory write 101 and trap 11x. The sequences are load 000,001,011; store 000,001,101; add 000,001,100,010. Every instruction then returns to 000.
- R6: The accumulator write enable is high only in states 011 and 010. The data-memory write enable is high only in 101. The operand select equals state bit 0: 1 takes memory data, 0 takes the adder result. The accumulator holds whenever its write enable is low.
- R7: Operation code 11 leads from operand read to the trap state 110. The controller stays there for good with the error output high, no write enable asserted, and the program counter and accumulator frozen.
- R8: The program counter rises by exactly one per instruction, at the end of the fetch state. It wraps from 63 to 0.
- R9: The completion pulse is high for one cycle in the last state of each instruction (011, 101 or 010) and in no other state.
- R10: The test port writes the data memory when its select is 1 and the instruction memory when it is 0. The peek port returns the current data-memory word at its address with no delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tp_we | input | 1 | Test port write strobe |
| tp_to_dm | input | 1 | Test port target: 1 data memory, 0 instruction memory |
| tp_addr | input | 6 | Test port word address |
| tp_wdata | input | 8 | Test port write data |
| peek_addr | input | 6 | Data-memory peek address |
| peek_data | output | 8 | Data-memory word at peek_addr |
| acc_out | output | 8 | Accumulator value |
| pc_out | output | 6 | Program counter |
| state_out | output | 3 | Controller state code |
| acc_we | output | 1 | Accumulator write enable |
| dm_we | output | 1 | Data-memory write enable |
| mux_sel | output | 1 | Accumulator source select |
| instr_done | output | 1 | Last cycle of an instruction |
| err | output | 1 | Controller is in the trap state |

## Verification
The add path is swept over a grid of operand pairs: accumulator values stepping by 15 and memory values stepping by 13 across 0 to 255. This grid covers sums below and above 256, so a wrap error or a swapped operand select shows up as a wrong value. Each grid case runs load, add and store in turn and checks the state sequence and enables in every cycle. A separate run fills all 64 instruction words with loads of distinct values and executes past the end of memory. That run tells a correct increment-and-wrap of the program counter apart from a skipped or doubled fetch. A final program places the unused code after a valid load, which shows that the trap holds and freezes all state.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  typedef enum logic [2:0] {
    ST_FETCH = 3'b000,
    ST_OPND  = 3'b001,
    ST_WRACC = 3'b010,
    ST_LDACC = 3'b011,
    ST_ADD   = 3'b100,
    ST_WRDM  = 3'b101,
    ST_TRAP  = 3'b110,
    ST_TRAP2 = 3'b111
  } state_e;

  typedef enum logic [1:0] {
    OP_LD  = 2'b00,
    OP_ST  = 2'b01,
    OP_ADD = 2'b10,
    OP_BAD = 2'b11
  } op_e;

  localparam int OP_W = 2;

endpackage

// File: rtl/acc_mem.sv
module acc_mem #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr_a,
  output logic [WIDTH-1:0]  rdata_a,
  input  logic [ADDR_W-1:0] raddr_b,
  output logic [WIDTH-1:0]  rdata_b
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata_a = mem_q[raddr_a];
  assign rdata_b = mem_q[raddr_b];

endmodule

// File: rtl/acc_ctrl.sv
module acc_ctrl
  import acc_cpu_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  op_e    opcode,
  output state_e state_q,
  output logic   acc_we,
  output logic   dm_we,
  output logic   mux_sel,
  output logic   ir_load,
  output logic   opnd_load,
  output logic   sum_load,
  output logic   instr_done,
  output logic   err
);
  state_e state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_FETCH: state_d = ST_OPND;
      ST_OPND: begin
        unique case (opcode)
          OP_LD:   state_d = ST_LDACC;
          OP_ST:   state_d = ST_WRDM;
          OP_ADD:  state_d = ST_ADD;
          default: state_d = ST_TRAP;
        endcase
      end
      ST_ADD:   state_d = ST_WRACC;
      ST_LDACC: state_d = ST_FETCH;
      ST_WRACC: state_d = ST_FETCH;
      ST_WRDM:  state_d = ST_FETCH;
      default:  state_d = state_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ST_FETCH;
    else     state_q <= state_d;
  end

  // Moore outputs: decoded from state alone
  always_comb begin
    acc_we     = 1'b0;
    dm_we      = 1'b0;
    instr_done = 1'b0;
    unique case (state_q)
      ST_LDACC: begin acc_we = 1'b1; instr_done = 1'b1; end
      ST_WRACC: begin acc_we = 1'b1; instr_done = 1'b1; end
      ST_WRDM:  begin dm_we  = 1'b1; instr_done = 1'b1; end
      default: ;
    endcase
  end

  assign mux_sel   = state_q[0];
  assign ir_load   = (state_q == ST_FETCH);
  assign opnd_load = (state_q == ST_OPND);
  assign sum_load  = (state_q == ST_ADD);
  assign err       = state_q[2] & state_q[1];

  p_fetch_next_r5: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_FETCH |=> state_q == ST_OPND);
  p_add_next_r5: assert property (@(posedge clk) disable iff (rst)
    state_q == ST_ADD |=> state_q == ST_WRACC);
  p_trap_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    err |=> err && !acc_we && !dm_we);
  p_we_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(acc_we && dm_we));
  p_done_return_r9: assert property (@(posedge clk) disable iff (rst)
    instr_done |=> state_q == ST_FETCH);

endmodule

// File: rtl/acc_datapath.sv
module acc_datapath #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6,
  parameter int OP_W   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   ir_load,
  input  logic                   opnd_load,
  input  logic                   sum_load,
  input  logic                   acc_we,
  input  logic                   mux_sel,
  input  logic [OP_W+ADDR_W-1:0] im_rdata,
  input  logic [DATA_W-1:0]      dm_rdata,
  output logic [ADDR_W-1:0]      pc_q,
  output logic [OP_W-1:0]        ir_op,
  output logic [ADDR_W-1:0]      ir_addr,
  output logic [DATA_W-1:0]      acc_q
);
  localparam int INSTR_W = OP_W + ADDR_W;

  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [ADDR_W-1:0] pc_next(input logic [ADDR_W-1:0] p);
    return p + 1'b1;
  endfunction

  logic [INSTR_W-1:0] ir_q;
  logic [DATA_W-1:0]  opnd_q;
  logic [DATA_W-1:0]  sum_q;
  logic [DATA_W-1:0]  acc_src;

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q   <= '0;
      ir_q   <= '0;
      opnd_q <= '0;
      sum_q  <= '0;
      acc_q  <= '0;
    end else begin
      if (ir_load) begin
        ir_q <= im_rdata;
        pc_q <= pc_next(pc_q);
      end
      if (opnd_load) opnd_q <= dm_rdata;
      if (sum_load)  sum_q  <= wrap_add(acc_q, opnd_q);
      if (acc_we)    acc_q  <= acc_src;
    end
  end

  assign acc_src = mux_sel ? opnd_q : sum_q;
  assign ir_op   = ir_q[INSTR_W-1 -: OP_W];
  assign ir_addr = ir_q[ADDR_W-1:0];

  p_pc_step_r8: assert property (@(posedge clk) disable iff (rst)
    ir_load |=> pc_q == pc_next($past(pc_q)));
  p_pc_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !ir_load |=> $stable(pc_q));
  p_acc_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !acc_we |=> $stable(acc_q));

endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tp_we,
  input  logic              tp_to_dm,
  input  logic [ADDR_W-1:0] tp_addr,
  input  logic [DATA_W-1:0] tp_wdata,
  input  logic [ADDR_W-1:0] peek_addr,
  output logic [DATA_W-1:0] peek_data,
  output logic [DATA_W-1:0] acc_out,
  output logic [ADDR_W-1:0] pc_out,
  output logic [2:0]        state_out,
  output logic              acc_we,
  output logic              dm_we,
  output logic              mux_sel,
  output logic              instr_done,
  output logic              err
);
  localparam int INSTR_W = OP_W + ADDR_W;

  state_e             state_q;
  logic               ir_load, opnd_load, sum_load;
  logic [OP_W-1:0]    ir_op;
  logic [ADDR_W-1:0]  ir_addr;
  logic [INSTR_W-1:0] im_rdata, im_unused;
  logic [DATA_W-1:0]  dm_rdata;
  logic               im_we, dm_wr;
  logic [ADDR_W-1:0]  dm_waddr;
  logic [DATA_W-1:0]  dm_wdata;

  acc_ctrl u_ctrl (
    .clk(clk), .rst(rst), .opcode(op_e'(ir_op)), .state_q(state_q),
    .acc_we(acc_we), .dm_we(dm_we), .mux_sel(mux_sel), .ir_load(ir_load),
    .opnd_load(opnd_load), .sum_load(sum_load), .instr_done(instr_done),
    .err(err)
  );

  acc_datapath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .OP_W(OP_W)) u_dp (
    .clk(clk), .rst(rst), .ir_load(ir_load), .opnd_load(opnd_load),
    .sum_load(sum_load), .acc_we(acc_we), .mux_sel(mux_sel),
    .im_rdata(im_rdata), .dm_rdata(dm_rdata), .pc_q(pc_out),
    .ir_op(ir_op), .ir_addr(ir_addr), .acc_q(acc_out)
  );

  assign im_we    = tp_we & ~tp_to_dm;
  assign dm_wr    = (tp_we & tp_to_dm) | dm_we;
  assign dm_waddr = (tp_we & tp_to_dm) ? tp_addr : ir_addr;
  assign dm_wdata = (tp_we & tp_to_dm) ? tp_wdata : acc_out;

  acc_mem #(.WIDTH(INSTR_W), .ADDR_W(ADDR_W)) u_imem (
    .clk(clk), .we(im_we), .waddr(tp_addr), .wdata(tp_wdata[INSTR_W-1:0]),
    .raddr_a(pc_out), .rdata_a(im_rdata), .raddr_b(tp_addr), .rdata_b(im_unused)
  );

  acc_mem #(.WIDTH(DATA_W), .ADDR_W(ADDR_W)) u_dmem (
    .clk(clk), .we(dm_wr), .waddr(dm_waddr), .wdata(dm_wdata),
    .raddr_a(ir_addr), .rdata_a(dm_rdata), .raddr_b(peek_addr), .rdata_b(peek_data)
  );

  assign state_out = state_q;

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> state_out == 3'b000 && acc_out == '0 && pc_out == '0);
  p_store_lands_r3: assert property (@(posedge clk) disable iff (rst)
    dm_we && !tp_we |=> u_dmem.mem_q[$past(ir_addr)] == $past(acc_out));

endmodule

// File: tb/acc_cpu_bench.sv
module acc_cpu_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tp_we = 1'b0, tp_to_dm = 1'b0;
  logic [5:0] tp_addr = '0, peek_addr = '0;
  logic [7:0] tp_wdata = '0;
  logic [7:0] peek_data, acc_out;
  logic [5:0] pc_out;
  logic [2:0] state_out;
  logic       acc_we, dm_we, mux_sel, instr_done, err;

  int total = 0, fails = 0, cyc = 0;
  bit ended = 0;

  always #10 clk = ~clk;

  acc_cpu u_acc_cpu (
    .clk(clk), .rst(rst), .tp_we(tp_we), .tp_to_dm(tp_to_dm), .tp_addr(tp_addr),
    .tp_wdata(tp_wdata), .peek_addr(peek_addr), .peek_data(peek_data),
    .acc_out(acc_out), .pc_out(pc_out), .state_out(state_out), .acc_we(acc_we),
    .dm_we(dm_we), .mux_sel(mux_sel), .instr_done(instr_done), .err(err)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tp_write(input bit to_dm, input int a, input int d);
    tp_we = 1'b1; tp_to_dm = to_dm; tp_addr = 6'(a); tp_wdata = 8'(d);
    @(negedge clk);
    tp_we = 1'b0;
  endtask

  task automatic start;
    @(negedge clk);
    rst = 1'b0;
  endtask

  // at entry: negedge in fetch state; returns at negedge after completion
  task automatic do_instr(input int op);
    int seq[4];
    int len;
    case (op)
      0: begin seq = '{0, 1, 3, 0}; len = 3; end
      1: begin seq = '{0, 1, 5, 0}; len = 3; end
      default: begin seq = '{0, 1, 4, 2}; len = 4; end
    endcase
    for (int i = 0; i < len; i++) begin
      chk("R5 state", state_out, seq[i]);
      chk("R6 acc_we", acc_we, (seq[i] == 3 || seq[i] == 2) ? 1 : 0);
      chk("R6 dm_we", dm_we, (seq[i] == 5) ? 1 : 0);
      if (acc_we) chk("R6 mux_sel", mux_sel, seq[i] % 2);
      chk("R9 done", instr_done, (i == len - 1) ? 1 : 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int a, b, s;
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1 state", state_out, 0);
    chk("R1 pc", pc_out, 0);
    chk("R1 acc", acc_out, 0);
    chk("R1 enables", {acc_we, dm_we, instr_done, err}, 0);

    // R2 R3 R4 R10: sweep of add operands
    for (int ia = 0; ia < 18; ia++) begin
      for (int ib = 0; ib < 20; ib++) begin
        a = ia * 15; b = (ib * 13) % 256; s = (a + b) % 256;
        rst = 1'b1;
        tp_write(0, 0, 8'h0A);
        tp_write(0, 1, 8'h8B);
        tp_write(0, 2, 8'h4C);
        tp_write(1, 10, a);
        tp_write(1, 11, b);
        tp_write(1, 12, 8'h5A);
        peek_addr = 6'd11;
        #1 chk("R10 peek", peek_data, b);
        start();
        do_instr(0);
        chk("R2 load acc", acc_out, a);
        chk("R8 pc", pc_out, 1);
        do_instr(2);
        chk("R4 add acc", acc_out, s);
        do_instr(1);
        peek_addr = 6'd12;
        #1 chk("R3 stored", peek_data, s);
        chk("R3 acc kept", acc_out, s);
        chk("R8 pc", pc_out, 3);
      end
    end

    // R8: run past the end of instruction memory
    rst = 1'b1;
    for (int k = 0; k < 64; k++) begin
      tp_write(0, k, k);
      tp_write(1, k, (k * 7 + 3) % 256);
    end
    start();
    for (int k = 0; k < 70; k++) begin
      do_instr(0);
      chk("R8 pc wrap", pc_out, (k + 1) % 64);
      chk("R2 load seq", acc_out, ((k % 64) * 7 + 3) % 256);
    end

    // R7: trap on unused code
    rst = 1'b1;
    tp_write(0, 0, 8'h05);
    tp_write(0, 1, 8'hC7);
    tp_write(1, 5, 8'h99);
    tp_write(1, 7, 8'h11);
    start();
    do_instr(0);
    chk("R7 pre acc", acc_out, 8'h99);
    chk("R7 fetch", state_out, 0);
    @(negedge clk);
    chk("R7 opnd", state_out, 1);
    chk("R7 err low", err, 0);
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk("R7 trap state", state_out, 6);
      chk("R7 err", err, 1);
      chk("R7 no we", {acc_we, dm_we, instr_done}, 0);
      chk("R7 pc frozen", pc_out, 2);
      chk("R7 acc frozen", acc_out, 8'h99);
    end
    peek_addr = 6'd7;
    #1 chk("R7 dm kept", peek_data, 8'h11);

    // R1: reset leaves trap
    rst = 1'b1;
    @(negedge clk);
    chk("R1 trap cleared", state_out, 0);
    chk("R1 err cleared", err, 0);
    chk("R1 acc cleared", acc_out, 0);

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !ended) begin
      ended = 1;
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 150000);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule